// File: doc/BRIEF.md
# Serial Loader for Dual-PLL Divider Registers

This block receives 22-bit control words over a three-line serial bus (data, shift clock, enable) and steers each word into one of four control registers that set up two frequency synthesizers. Each synthesizer has a reference-divider register and a main-divider register. All three bus lines are synchronized into the system clock domain, so the serial clock is never used as a clock.

A word is shifted in most significant bit first while enable is low. The two bits received last pick the destination register. The word takes effect only when enable rises. The decoded fields are driven as parallel outputs:

- for each reference register: the 15-bit reference ratio, the phase-detector polarity bit and four spare mode bits;
- for each main register: the 11-bit B count, the 7-bit A count and two spare bits.

Words with the wrong length are dropped and flagged. Reference words that would set a ratio below 3 are refused.

Top module: `synth_word_loader`

## Requirements
- R1: While ser_en is low, each rising edge of ser_clk shifts ser_data into a 22-bit word, first bit received becoming bit 21. The word is applied only when ser_en goes from low to high.
- R2: Word bits [1:0] choose the destination. 00 selects the PLL2 reference register, 01 the PLL2 main register, 10 the PLL1 reference register and 11 the PLL1 main register. The other three registers are left unchanged.
- R3: In a reference word, bits [16:2] are the ratio, bit 17 is the phase-detector polarity (1 positive, 0 negative) and bits [21:18] are spare mode bits. All three are driven unchanged on the outputs of that register.
- R4: In a main word, bits [8:2] are the A count, bits [19:9] the B count and bits [21:20] spare bits. All three are driven unchanged on the outputs of that register.
- R5: If the number of ser_clk rising edges seen while ser_en was low is not exactly 22, the word is discarded when ser_en rises. In that case frame_err is high for exactly one system clock and no register or valid flag changes.
- R6: A reference word whose ratio field is 0, 1 or 2 is refused. The register keeps its old contents, its valid flag does not change and frame_err stays low.
- R7: Reset clears all four registers, valid and frame_err to zero. A valid bit (index equal to the select code) goes high when its register is first loaded and never falls until the next reset.
- R8: ser_clk edges that occur while ser_en is high neither shift data nor count toward the word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Serial enable: low while shifting, rising edge commits |
| pll2_ref_div | output | 15 | PLL2 reference ratio |
| pll2_pd_pos | output | 1 | PLL2 phase-detector polarity, 1 = positive |
| pll2_ref_rsv | output | 4 | PLL2 spare mode bits |
| pll2_b | output | 11 | PLL2 B count |
| pll2_a | output | 7 | PLL2 A count |
| pll2_main_rsv | output | 2 | PLL2 main-register spare bits |
| pll1_ref_div | output | 15 | PLL1 reference ratio |
| pll1_pd_pos | output | 1 | PLL1 phase-detector polarity, 1 = positive |
| pll1_ref_rsv | output | 4 | PLL1 spare mode bits |
| pll1_b | output | 11 | PLL1 B count |
| pll1_a | output | 7 | PLL1 A count |
| pll1_main_rsv | output | 2 | PLL1 main-register spare bits |
| valid | output | 4 | Per-register loaded flags, indexed by select code |
| frame_err | output | 1 | One-cycle pulse when a wrong-length word is dropped |

## Verification
All four select codes are driven with walking-one, all-ones, alternating and mixed payloads. The walking-one patterns expose swapped or shifted field boundaries. The all-ones and alternating patterns expose a register that is written by the wrong select code or loses a bit. The reference ratio is swept from 0 to 4 on both reference registers, which separates the refusal of 0, 1 and 2 from the acceptance of 3. Word lengths of 0, 1, 21, 23 and 30 edges separate off-by-one length errors from correct framing. A burst of ser_clk edges sent while enable is high, followed by a correct word, shows whether edges outside a frame are wrongly counted.

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int WORD_W  = 22,
  parameter int DIV_W   = 15,
  parameter int MIN_DIV = 3,
  parameter int B_W     = 11,
  parameter int A_W     = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk,
  input  logic                          ser_data,
  input  logic                          ser_en,
  output logic [DIV_W-1:0]              pll2_ref_div,
  output logic                          pll2_pd_pos,
  output logic [WORD_W-DIV_W-4:0]       pll2_ref_rsv,
  output logic [B_W-1:0]                pll2_b,
  output logic [A_W-1:0]                pll2_a,
  output logic [WORD_W-B_W-A_W-3:0]     pll2_main_rsv,
  output logic [DIV_W-1:0]              pll1_ref_div,
  output logic                          pll1_pd_pos,
  output logic [WORD_W-DIV_W-4:0]       pll1_ref_rsv,
  output logic [B_W-1:0]                pll1_b,
  output logic [A_W-1:0]                pll1_a,
  output logic [WORD_W-B_W-A_W-3:0]     pll1_main_rsv,
  output logic [3:0]                    valid,
  output logic                          frame_err
);
  localparam int PAY_W = WORD_W - 2;
  localparam int CNT_W = $clog2(WORD_W + 2) + 1;

  logic [2:0] ck_q, dt_q, en_q;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] regs [4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
      en_q <= '1;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      dt_q <= {dt_q[1:0], ser_data};
      en_q <= {en_q[1:0], ser_en};
    end

  wire       shift_now = ck_q[1] & ~ck_q[2] & ~en_q[1];
  wire       commit    = en_q[1] & ~en_q[2];
  wire [1:0] sel       = sh[1:0];
  wire       len_ok    = (cnt == CNT_W'(WORD_W));
  wire       ratio_bad = ~sel[0] & (sh[DIV_W+1:2] < DIV_W'(MIN_DIV));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      valid     <= '0;
      frame_err <= 1'b0;
      for (int i = 0; i < 4; i++) regs[i] <= '0;
    end else begin
      frame_err <= 1'b0;
      if (shift_now) begin
        sh <= {sh[WORD_W-2:0], dt_q[1]};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
      if (commit) begin
        cnt <= '0;
        if (!len_ok) frame_err <= 1'b1;
        else if (!ratio_bad) begin
          regs[sel]  <= sh[WORD_W-1:2];
          valid[sel] <= 1'b1;
        end
      end
    end

  assign pll2_ref_div  = regs[0][DIV_W-1:0];
  assign pll2_pd_pos   = regs[0][DIV_W];
  assign pll2_ref_rsv  = regs[0][PAY_W-1:DIV_W+1];
  assign pll2_a        = regs[1][A_W-1:0];
  assign pll2_b        = regs[1][A_W+B_W-1:A_W];
  assign pll2_main_rsv = regs[1][PAY_W-1:A_W+B_W];
  assign pll1_ref_div  = regs[2][DIV_W-1:0];
  assign pll1_pd_pos   = regs[2][DIV_W];
  assign pll1_ref_rsv  = regs[2][PAY_W-1:DIV_W+1];
  assign pll1_a        = regs[3][A_W-1:0];
  assign pll1_b        = regs[3][A_W+B_W-1:A_W];
  assign pll1_main_rsv = regs[3][PAY_W-1:A_W+B_W];
endmodule

// File: rtl/synth_word_loader_chk.sv
module synth_word_loader_chk #(
  parameter int DIV_W = 15,
  parameter int ST_W  = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       valid,
  input logic             frame_err,
  input logic [DIV_W-1:0] pll2_ref_div,
  input logic [DIV_W-1:0] pll1_ref_div,
  input logic [ST_W-1:0]  state
);
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(valid) & ~valid) == 4'b0));

  assert_pll2_ratio_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid[0] |-> (pll2_ref_div >= DIV_W'(3)));

  assert_pll1_ratio_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid[2] |-> (pll1_ref_div >= DIV_W'(3)));

  assert_frame_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(state) && $stable(valid)));

  assert_frame_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

bind synth_word_loader synth_word_loader_chk #(.DIV_W(DIV_W), .ST_W(4 * (WORD_W - 2))) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .frame_err(frame_err),
  .pll2_ref_div(pll2_ref_div), .pll1_ref_div(pll1_ref_div),
  .state({pll2_ref_rsv, pll2_pd_pos, pll2_ref_div, pll2_main_rsv, pll2_b, pll2_a,
          pll1_ref_rsv, pll1_pd_pos, pll1_ref_div, pll1_main_rsv, pll1_b, pll1_a})
);

// File: tb/tb_synth_word_loader.sv
module tb_synth_word_loader;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_en = 1;
  logic [14:0] p2_div, p1_div;
  logic p2_pol, p1_pol, frame_err;
  logic [3:0] p2_rsv, p1_rsv, valid;
  logic [10:0] p2_b, p1_b;
  logic [6:0] p2_a, p1_a;
  logic [1:0] p2_mrsv, p1_mrsv;

  always #4 clk = ~clk;

  synth_word_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .pll2_ref_div(p2_div), .pll2_pd_pos(p2_pol), .pll2_ref_rsv(p2_rsv),
    .pll2_b(p2_b), .pll2_a(p2_a), .pll2_main_rsv(p2_mrsv),
    .pll1_ref_div(p1_div), .pll1_pd_pos(p1_pol), .pll1_ref_rsv(p1_rsv),
    .pll1_b(p1_b), .pll1_a(p1_a), .pll1_main_rsv(p1_mrsv),
    .valid(valid), .frame_err(frame_err));

  int checks = 0, errors = 0, fe_seen = 0;
  logic [19:0] model [4];
  logic [3:0] mvalid;

  always @(posedge clk) if (rst_n && frame_err) fe_seen++;

  function automatic logic [19:0] out_word(input int s);
    case (s)
      0: return {p2_rsv, p2_pol, p2_div};
      1: return {p2_mrsv, p2_b, p2_a};
      2: return {p1_rsv, p1_pol, p1_div};
      default: return {p1_mrsv, p1_b, p1_a};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 4; s++) chk(req, 32'(out_word(s)), 32'(model[s]));
    chk(req, 32'(valid), 32'(mvalid));
  endtask

  task automatic send(input logic [21:0] w, input int n, input string req);
    int fe0;
    logic exp_fe;
    fe0 = fe_seen;
    @(negedge clk) ser_en = 0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i % 22];
      repeat (4) @(negedge clk);
      ser_clk = 1;
      repeat (4) @(negedge clk);
      ser_clk = 0;
    end
    repeat (4) @(negedge clk);
    ser_en = 1;
    repeat (10) @(negedge clk);
    exp_fe = (n != 22);
    if (!exp_fe && !(w[0] == 1'b0 && w[16:2] < 3)) begin
      model[w[1:0]] = w[21:2];
      mvalid[w[1:0]] = 1'b1;
    end
    check_all(req);
    chk({req, " frame_err"}, 32'(fe_seen - fe0), exp_fe ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) model[s] = '0;
    mvalid = '0;
    repeat (5) @(negedge clk);
    chk("R7 reset frame_err", 32'(frame_err), 0);
    check_all("R7 reset state");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4: routing and field placement over every select code
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++)
        send({20'(20'h1 << (k * 4 + s)) | 20'h00018, 2'(s)}, 22, "R1 R2 R3 R4 walking one");
      send({20'hFFFFF, 2'(s)}, 22, "R2 R3 R4 all ones");
      send({20'hAAAA8, 2'(s)}, 22, "R2 R3 R4 alternating");
      send({20'(20'h3C5A7 + s * 20'h1111), 2'(s)}, 22, "R1 R2 mixed");
    end
    // R3 polarity both ways on both reference registers
    send({1'b0, 4'h9, 1'b1, 15'd64, 1'b0, 1'b0}, 22, "R3 pll2 polarity positive");
    send({1'b0, 4'h6, 1'b0, 15'd16, 1'b1, 1'b0}, 22, "R3 pll1 polarity negative");
    // R6 ratio floor sweep
    for (int r = 0; r < 5; r++) begin
      send({5'h11, 15'(r), 2'b00}, 22, "R6 pll2 ratio sweep");
      send({5'h0A, 15'(r), 2'b10}, 22, "R6 pll1 ratio sweep");
    end
    // R4 main word with B/A values sized like a real divider setting
    send({2'b10, 11'd260, 7'd32, 2'b01}, 22, "R4 pll2 main");
    send({2'b01, 11'd99, 7'd12, 2'b11}, 22, "R4 pll1 main");
    // R5 wrong lengths
    send({20'h12345, 2'b01}, 0,  "R5 length 0");
    send({20'h12345, 2'b01}, 1,  "R5 length 1");
    send({20'h54321, 2'b11}, 21, "R5 length 21");
    send({20'h6789A, 2'b11}, 23, "R5 length 23");
    send({20'hABCDE, 2'b00}, 30, "R5 length 30");
    // R8 edges while enable high are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) ser_data = 1;
      repeat (4) @(negedge clk) ser_clk = 1;
      repeat (4) @(negedge clk) ser_clk = 0;
    end
    repeat (6) @(negedge clk);
    chk("R8 no change after idle edges", 32'(out_word(1)), 32'(model[1]));
    send({2'b11, 11'd777, 7'd5, 2'b01}, 22, "R8 word after idle edges");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule